// File: doc/BRIEF.md
# Scroll Window Address Translator

This block scrolls a region of a bitmap display vertically without moving any video memory contents. It maps a linear address to a physical address. Inside a programmable window, which runs from a start address up to an end address and always spans full lines, an address is rotated by a scroll offset and wrapped back into the window. Addresses outside the window keep their value. Each scroll step therefore drops the top line of the window from view. The same physical line then appears as the new bottom line, and the CPU clears it before the step.

The raster address generator uses a registered display port. The CPU uses a separate combinational port that applies the same mapping. This way the CPU sees memory in the same order as the screen. Software writes the start address, the end address and the offset into pending registers. It can also add one line step to the pending offset. The pending offset is reduced modulo the pending window length in the background. All three values move to the active set together on the next frame-start pulse, so a frame is never torn mid-scan.

Top module: `scroll_xlat`

## Requirements
- R1: While rst_ni is low, and after it rises until a frame start loads new values, the active start, end and offset are zero. The window is then empty, `cpu_addr_o` equals `cpu_addr_i`, and `disp_addr_o` is zero during reset.
- R2: An address below the active start or at or above the active end is returned unchanged on both ports.
- R3: An address A with start <= A < end maps to A + offset. If that sum is at or above end, the window length (end - start) is subtracted.
- R4: When the active start is not below the active end, the window is empty and every address passes through unchanged.
- R5: `disp_addr_o` is the mapping of the `disp_addr_i` value sampled at the previous rising clock edge, using the active values of that edge. `cpu_addr_o` is a combinational mapping of `cpu_addr_i` and does not depend on the display port.
- R6: A write with `cfg_we_i` high goes to a pending value selected by `cfg_sel_i`: 0 = start, 1 = end, 2 = offset (set to `cfg_wdata_i`), 3 = add one line step (LINE_STEP) to the pending offset. A pending value does not affect the mapping until the next `frame_start_i` pulse.
- R7: The pending offset is reduced modulo the pending window length after each write, subtracting one length per cycle. A written offset at or above the length therefore behaves as its remainder. A frame start that arrives while the reduction is still running keeps the previous active values.
- R8: With an offset of one line step, the address one line step below the end maps to the window start, and the window start maps one line step further down.
- R9: In a non-empty active window, the active offset is always below the window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle pulse at frame start; loads pending values into the active set |
| cfg_we_i | input | 1 | Pending-register write strobe |
| cfg_sel_i | input | 2 | Write target: 0 start, 1 end, 2 offset, 3 add line step |
| cfg_wdata_i | input | ADDR_W | Write data for start, end or offset |
| disp_addr_i | input | ADDR_W | Linear display address from the raster generator |
| disp_addr_o | output | ADDR_W | Physical display address, one cycle later |
| cpu_addr_i | input | ADDR_W | CPU-side linear address |
| cpu_addr_o | output | ADDR_W | Physical CPU address, combinational |

## Verification
A wrong active register or a bad wrap compare shows up on `cpu_addr_o` in the same cycle an affected address is presented. It shows up on `disp_addr_o` one clock later. Random addresses hit the window, its edges and the area outside it on every cycle. A pending value that leaks into the active set early changes the mapping of in-window addresses before the frame-start pulse. An offset that is not fully reduced moves in-window addresses out of the window, or to the wrong line, at the first frame after the write.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_END    = 2'd1,
    SEL_OFFSET = 2'd2,
    SEL_STEP   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/win_map.sv
module win_map #(
  parameter int AW = 17
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic [AW-1:0] off_i,
  output logic [AW-1:0] addr_o
);
  logic [AW:0] sum, len, wrapped;
  logic        in_win;

  always_comb begin
    in_win  = (start_i < end_i) && (addr_i >= start_i) && (addr_i < end_i);
    sum     = {1'b0, addr_i} + {1'b0, off_i};
    len     = {1'b0, end_i} - {1'b0, start_i};
    // off_i < len, so one subtraction always lands back inside the window
    wrapped = (sum >= {1'b0, end_i}) ? sum - len : sum;
    addr_o  = in_win ? wrapped[AW-1:0] : addr_i;
  end
endmodule

// File: rtl/scroll_cfg.sv
module scroll_cfg
  import scroll_pkg::*;
#(
  parameter int AW        = 17,
  parameter int LINE_STEP = 640
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] act_start_o,
  output logic [AW-1:0] act_end_o,
  output logic [AW-1:0] act_off_o
);
  localparam logic [AW:0] STEP_W = (AW+1)'(LINE_STEP);

  logic [AW-1:0] pend_start, pend_end;
  logic [AW:0]   pend_off, pend_len;
  logic          busy;

  assign pend_len = (pend_start < pend_end) ? ({1'b0, pend_end} - {1'b0, pend_start})
                                            : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_start <= '0;
      pend_end   <= '0;
      pend_off   <= '0;
      busy       <= 1'b0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_START:  pend_start <= wdata_i;
        SEL_END:    pend_end   <= wdata_i;
        SEL_OFFSET: pend_off   <= {1'b0, wdata_i};
        SEL_STEP:   pend_off   <= pend_off + STEP_W;
        default:    pend_off   <= pend_off;
      endcase
      busy <= 1'b1;
    end else if (busy) begin
      if (pend_len == '0)            busy     <= 1'b0;
      else if (pend_off >= pend_len) pend_off <= pend_off - pend_len;
      else                           busy     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_start_o <= '0;
      act_end_o   <= '0;
      act_off_o   <= '0;
    end else if (frame_start_i && !busy) begin
      act_start_o <= pend_start;
      act_end_o   <= pend_end;
      act_off_o   <= pend_off[AW-1:0];
    end
  end
endmodule

// File: rtl/scroll_xlat.sv
module scroll_xlat #(
  parameter int ADDR_W    = 17,
  parameter int LINE_STEP = 640
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic [ADDR_W-1:0] disp_addr_i,
  output logic [ADDR_W-1:0] disp_addr_o,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [ADDR_W-1:0] cpu_addr_o
);
  logic [ADDR_W-1:0] act_start, act_end, act_off;
  logic [ADDR_W-1:0] disp_map;

  scroll_cfg #(.AW(ADDR_W), .LINE_STEP(LINE_STEP)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .we_i         (cfg_we_i),
    .sel_i        (cfg_sel_i),
    .wdata_i      (cfg_wdata_i),
    .act_start_o  (act_start),
    .act_end_o    (act_end),
    .act_off_o    (act_off)
  );

  win_map #(.AW(ADDR_W)) u_map_disp (
    .addr_i (disp_addr_i),
    .start_i(act_start),
    .end_i  (act_end),
    .off_i  (act_off),
    .addr_o (disp_map)
  );

  win_map #(.AW(ADDR_W)) u_map_cpu (
    .addr_i (cpu_addr_i),
    .start_i(act_start),
    .end_i  (act_end),
    .off_i  (act_off),
    .addr_o (cpu_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) disp_addr_o <= '0;
    else         disp_addr_o <= disp_map;
  end
endmodule

// File: rtl/scroll_xlat_chk.sv
module scroll_xlat_chk #(
  parameter int AW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_start_i,
  input logic [AW-1:0] disp_addr_i,
  input logic [AW-1:0] disp_addr_o,
  input logic [AW-1:0] cpu_addr_i,
  input logic [AW-1:0] cpu_addr_o,
  input logic [AW-1:0] act_start_i,
  input logic [AW-1:0] act_end_i,
  input logic [AW-1:0] act_off_i
);
  logic seen_q;
  logic cpu_in, disp_in, win_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign win_ok  = act_start_i < act_end_i;
  assign cpu_in  = win_ok && cpu_addr_i >= act_start_i && cpu_addr_i < act_end_i;
  assign disp_in = win_ok && disp_addr_i >= act_start_i && disp_addr_i < act_end_i;

  // R2 / R4
  a_r2_cpu_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_in |-> cpu_addr_o == cpu_addr_i);

  // R3
  a_r3_cpu_stays_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_in |-> (cpu_addr_o >= act_start_i && cpu_addr_o < act_end_i));

  // R5
  a_r5_disp_passthru_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(!disp_in)) |-> disp_addr_o == $past(disp_addr_i));

  a_r5_disp_in_window_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(disp_in)) |->
      (disp_addr_o >= $past(act_start_i) && disp_addr_o < $past(act_end_i)));

  // R6
  a_r6_hold_between_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> ($stable(act_start_i) && $stable(act_end_i) && $stable(act_off_i)));

  // R9
  a_r9_offset_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_ok |-> act_off_i < (act_end_i - act_start_i));
endmodule

bind scroll_xlat scroll_xlat_chk #(.AW(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .disp_addr_i  (disp_addr_i),
  .disp_addr_o  (disp_addr_o),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_addr_o   (cpu_addr_o),
  .act_start_i  (act_start),
  .act_end_i    (act_end),
  .act_off_i    (act_off)
);

// File: tb/sim_scroll_xlat.sv
`timescale 1ns/1ps
module sim_scroll_xlat;
  localparam int AW   = 17;
  localparam int STEP = 640;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fs = 1'b0, we = 1'b0;
  logic [1:0]    sel = '0;
  logic [AW-1:0] wd = '0, disp_a = '0, cpu_a = '0;
  logic [AW-1:0] disp_o, cpu_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // reference model state
  int m_start = 0, m_end = 0, m_off = 0;
  int p_start = 0, p_end = 0, p_off = 0;
  int exp_disp = 0;

  always #5 clk = ~clk;

  scroll_xlat #(.ADDR_W(AW), .LINE_STEP(STEP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wd),
    .disp_addr_i(disp_a), .disp_addr_o(disp_o),
    .cpu_addr_i(cpu_a), .cpu_addr_o(cpu_o)
  );

  function automatic int ref_map(int a, int s, int e, int o);
    int r;
    r = a;
    if (s < e && a >= s && a < e) begin
      r = a + o;
      if (r >= e) r = r - (e - s);
    end
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_end = 0; m_off = 0;
      p_start = 0; p_end = 0; p_off = 0;
      exp_disp = 0;
    end else begin
      exp_disp = ref_map(int'(disp_a), m_start, m_end, m_off);
      if (fs) begin
        m_start = p_start; m_end = p_end; m_off = p_off;
      end
      if (we) begin
        case (sel)
          2'd0: p_start = int'(wd);
          2'd1: p_end   = int'(wd);
          2'd2: p_off   = int'(wd);
          default: p_off = p_off + STEP;
        endcase
        if (p_start < p_end) p_off = p_off % (p_end - p_start);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3/R4 cpu", int'(cpu_o), ref_map(int'(cpu_a), m_start, m_end, m_off));
      chk("R5 disp", int'(disp_o), exp_disp);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [1:0] s, int v);
    @(posedge clk); #2;
    we = 1'b1; sel = s; wd = AW'(v);
    @(posedge clk); #2;
    we = 1'b0;
    cyc(12);
  endtask

  task automatic frame();
    @(posedge clk); #2;
    fs = 1'b1;
    @(posedge clk); #2;
    fs = 1'b0;
  endtask

  task automatic cpu_chk(string tag, int a, int exp);
    cpu_a = AW'(a);
    #1;
    chk(tag, int'(cpu_o), exp);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cpu_a = 17'd1234; disp_a = 17'd77;
    #1;
    chk("R1 cpu in reset", int'(cpu_o), 1234);
    chk("R1 disp in reset", int'(disp_o), 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc(1);
    cpu_chk("R1 empty after reset", 50000, 50000);

    wr(2'd0, 6400);
    wr(2'd1, 32000);
    wr(2'd2, 1920);
    cpu_chk("R6 pending not applied", 6400, 6400);
    frame();
    cpu_chk("R3 start plus offset", 6400, 8320);
    cpu_chk("R3 wrap at end", 31999, 8319);
    cpu_chk("R2 below window", 100, 100);
    cpu_chk("R2 at end", 32000, 32000);
    cpu_chk("R2 just below start", 6399, 6399);

    wr(2'd2, STEP);
    frame();
    cpu_chk("R8 last line to start", 32000 - STEP, 6400);
    cpu_chk("R8 start moves one line", 6400, 6400 + STEP);

    wr(2'd3, 0);
    cpu_chk("R6 step pending", 6400, 6400 + STEP);
    frame();
    cpu_chk("R6 step applied", 6400, 6400 + 2*STEP);

    wr(2'd2, 100000);
    frame();
    cpu_chk("R7 reduced offset", 6400, 29600);
    cpu_chk("R7 reduced offset wrap", 9000, 6600);

    @(posedge clk); #2;
    disp_a = 17'd6400;
    #1;
    chk("R5 disp holds before edge", int'(disp_o), exp_disp);
    cyc(1);
    chk("R5 disp after one edge", int'(disp_o), 29600);

    wr(2'd0, 32000);
    frame();
    cpu_chk("R4 empty window", 20000, 20000);
    cpu_chk("R4 empty window low", 6400, 6400);
    wr(2'd0, 6400);
    frame();
    cpu_chk("R7 offset kept across empty", 6400, 29600);

    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #2;
      cpu_a  = AW'($urandom % 131072);
      disp_a = AW'((i % 7 == 0) ? 6400 + ($urandom % 25600) : ($urandom % 131072));
      we  = (i % 64 == 20);
      sel = 2'd3;
      fs  = (i % 64 == 40);
    end
    @(posedge clk); #2;
    we = 1'b0; fs = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule